// File: doc/BRIEF.md
# HDLC Receive Frame Length Limiter

This block sits in an HDLC receive path between the deframer and the buffer writer, and enforces a programmed maximum frame length. The deframer supplies frame bytes with a valid strobe. A start-of-frame strobe marks the first byte of a frame, and an end-of-frame strobe marks the cycle of the closing flag. Every byte between the two flags counts against the limit, whatever its role (address, control, payload or checksum). Bytes are forwarded unchanged while the limit still has room. Once a frame runs past the limit, the rest of that frame is suppressed.

The block does not report a truncated frame early. It keeps tracking the frame until its real closing flag arrives, and only then emits a single status record. The record holds the number of bytes actually forwarded and a too-long flag. The buffer writer uses this record to close its descriptor. Flag hunting, bit de-stuffing and checksum verification are done elsewhere.

Top module: `hdlc_rx_len_limiter`

## Requirements
- R1: A byte accepted within a frame while its budget remains appears on `out_data` with `out_vld` high exactly one clock after the input cycle, with the value unchanged. Idle input cycles inside a frame produce no output.
- R2: Bytes presented while no frame is open produce no output. An end strobe while no frame is open produces no status record. A frame is open from a start strobe until the next end strobe.
- R3: Every in-frame byte counts against the limit, including a byte that arrives together with the start or end strobe. A frame of exactly `max_len` bytes is forwarded whole, and its status shows that length with the too-long flag low.
- R4: After `max_len` bytes of a frame have been forwarded, every further byte of that frame is discarded, and `out_vld` stays low for it.
- R5: A status record is a one-cycle `sts_vld` pulse one clock after the end-strobe cycle. It carries `sts_len` equal to the bytes forwarded and `sts_too_long` high exactly when the frame held more bytes than its limit. No record is issued before the end strobe.
- R6: For a frame that was too long, `sts_len` equals the frame's limit.
- R7: A start strobe while a frame is still open abandons that frame without any status record. It reloads the budget and clears the discard state, so bytes of the new frame are forwarded again.
- R8: Start and end strobes in the same cycle form a complete frame. With a byte present the frame has length 1, and without one it has length 0. Either way its status follows one clock later.
- R9: The limit is sampled only in the start-strobe cycle. A change of `max_len` during a frame has no effect on that frame.
- R10: While reset is asserted, and in the first cycle after it, `out_vld` and `sts_vld` are low.
- R11: With a limit of zero, every byte of the frame is discarded. The status shows length 0, and the too-long flag is high only if the frame held at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_vld | input | 1 | Input byte valid |
| in_data | input | DATA_W | Input byte |
| in_sof | input | 1 | Start of frame; a byte in this cycle is the first byte |
| in_eof | input | 1 | End of frame; a byte in this cycle is the last byte |
| max_len | input | LEN_W | Maximum frame length in bytes, sampled at start of frame |
| out_vld | output | 1 | Forwarded byte valid |
| out_data | output | DATA_W | Forwarded byte |
| sts_vld | output | 1 | One-cycle status record strobe |
| sts_len | output | LEN_W | Bytes forwarded in the frame |
| sts_too_long | output | 1 | Frame exceeded its limit |

## Verification
Both results have a latency of one clock. A forwarded byte and a status record each appear in the cycle after the input cycle that caused them, because each passes through exactly one register stage. The bench drives inputs on the falling edge. On the next falling edge, before it drives anything new, it compares the outputs with the expected values that a frame-level model derived from the previous cycle's inputs. Each comparison therefore lands exactly one register stage after its stimulus, and never at an edge.

// File: rtl/hdlc_lim_pkg.sv
package hdlc_lim_pkg;

  // Frame phase as seen by the limiter
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,   // no frame open, bytes are ignored
    PH_PASS = 2'd1,   // frame open, budget not exceeded
    PH_DROP = 2'd2    // frame open, limit exceeded, bytes discarded
  } frame_ph_e;

endpackage

// File: rtl/hdlc_lim_budget.sv
// Remaining-byte budget: loaded with the limit at frame start, counts down per forwarded byte.
module hdlc_lim_budget #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sof,
  input  logic [LEN_W-1:0] max_len,
  input  logic             take,      // an in-frame byte is present this cycle
  output logic             rem_zero,  // no budget left for the byte of this cycle
  output logic [LEN_W-1:0] rem_q,
  output logic [LEN_W-1:0] lim_q,
  output logic [LEN_W-1:0] lim_n
);

  logic [LEN_W-1:0] rem_base;
  logic [LEN_W-1:0] rem_n;
  logic             rem_en;
  logic             lim_en;

  always_comb begin
    rem_base = in_sof ? max_len : rem_q;
    rem_zero = (rem_base == '0);
    rem_n    = rem_base;
    if (take && !rem_zero) begin
      rem_n = rem_base - LEN_W'(1);
    end
    rem_en = in_sof | take;
    lim_en = in_sof;
    lim_n  = lim_en ? max_len : lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else if (lim_en) begin
      lim_q <= lim_n;
    end
  end

  // R9: the latched limit only moves on a start strobe
  p_lim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sof |=> $stable(lim_q));

endmodule

// File: rtl/hdlc_lim_tracker.sv
// Frame phase and forwarded-length tally.
module hdlc_lim_tracker
  import hdlc_lim_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             rem_zero,
  output logic             take,
  output logic             pass,
  output logic             frame_end,
  output logic [LEN_W-1:0] len_n,
  output logic             too_long_n,
  output logic [LEN_W-1:0] len_q,
  output frame_ph_e        ph_q
);

  frame_ph_e        ph_base;
  frame_ph_e        ph_n;
  logic             active;
  logic             over;
  logic [LEN_W-1:0] len_base;
  logic             len_en;

  always_comb begin
    ph_base    = in_sof ? PH_PASS : ph_q;
    active     = (ph_base != PH_IDLE);
    take       = in_vld & active;
    pass       = take & ~rem_zero;
    over       = take & rem_zero;
    len_base   = in_sof ? '0 : len_q;
    len_n      = len_base + {{(LEN_W-1){1'b0}}, pass};
    len_en     = in_sof | pass;
    too_long_n = (ph_base == PH_DROP) | over;
    frame_end  = in_eof & active;
    if (!active || in_eof) begin
      ph_n = PH_IDLE;
    end else if (too_long_n) begin
      ph_n = PH_DROP;
    end else begin
      ph_n = PH_PASS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_n;
    end
  end

  // R7: a start strobe always leaves the frame open in pass phase unless it also ends it
  p_sof_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sof && !in_eof && !(in_vld && rem_zero)) |=> (ph_q == PH_PASS));

  // R2: with no frame open and no start strobe, the phase stays idle
  p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !in_sof) |=> (ph_q == PH_IDLE));

endmodule

// File: rtl/hdlc_lim_report.sv
// Output registers: gated byte stream and end-of-frame status record.
module hdlc_lim_report #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass,
  input  logic [DATA_W-1:0] in_data,
  input  logic              frame_end,
  input  logic [LEN_W-1:0]  len_n,
  input  logic              too_long_n,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              sts_vld,
  output logic [LEN_W-1:0]  sts_len,
  output logic              sts_too_long
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      sts_vld <= 1'b0;
    end else begin
      out_vld <= pass;
      sts_vld <= frame_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (pass) begin
      out_data <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_len      <= '0;
      sts_too_long <= 1'b0;
    end else if (frame_end) begin
      sts_len      <= len_n;
      sts_too_long <= too_long_n;
    end
  end

endmodule

// File: rtl/hdlc_rx_len_limiter.sv
module hdlc_rx_len_limiter
  import hdlc_lim_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [LEN_W-1:0]  max_len,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              sts_vld,
  output logic [LEN_W-1:0]  sts_len,
  output logic              sts_too_long
);

  localparam int unsigned SUM_W = LEN_W + 1;

  logic             take;
  logic             pass;
  logic             rem_zero;
  logic             frame_end;
  logic             too_long_n;
  logic [LEN_W-1:0] len_n;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] lim_q;
  logic [LEN_W-1:0] lim_n;
  frame_ph_e        ph_q;

  hdlc_lim_budget #(.LEN_W(LEN_W)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_sof   (in_sof),
    .max_len  (max_len),
    .take     (take),
    .rem_zero (rem_zero),
    .rem_q    (rem_q),
    .lim_q    (lim_q),
    .lim_n    (lim_n)
  );

  hdlc_lim_tracker #(.LEN_W(LEN_W)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .rem_zero   (rem_zero),
    .take       (take),
    .pass       (pass),
    .frame_end  (frame_end),
    .len_n      (len_n),
    .too_long_n (too_long_n),
    .len_q      (len_q),
    .ph_q       (ph_q)
  );

  hdlc_lim_report #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_report (
    .clk          (clk),
    .rst_n        (rst_n),
    .pass         (pass),
    .in_data      (in_data),
    .frame_end    (frame_end),
    .len_n        (len_n),
    .too_long_n   (too_long_n),
    .out_vld      (out_vld),
    .out_data     (out_data),
    .sts_vld      (sts_vld),
    .sts_len      (sts_len),
    .sts_too_long (sts_too_long)
  );

  // R3: within an open frame, forwarded bytes plus remaining budget equal the latched limit
  p_budget_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |->
      ((SUM_W'(len_q) + SUM_W'(rem_q)) == SUM_W'(lim_q)));

  // R4: once in discard phase, a continuing byte is never forwarded
  p_drop_after_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DROP && in_vld && !in_sof) |=> !out_vld);

  // R1: a forwarded byte always stems from an input byte one cycle earlier
  p_out_from_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

  // R5: a status record only follows an end strobe
  p_sts_after_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_vld |-> $past(in_eof));

  // R6: the reported length never exceeds the frame limit, and equals it when too long
  p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_vld |-> (sts_len <= $past(lim_n)));
  p_trunc_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_vld && sts_too_long) |-> (sts_len == $past(lim_n)));

endmodule

// File: tb/sim_hdlc_rx_len_limiter.sv
`timescale 1ns/1ps
module sim_hdlc_rx_len_limiter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [7:0]  in_data;
  logic        in_sof;
  logic        in_eof;
  logic [15:0] max_len;
  logic        out_vld;
  logic [7:0]  out_data;
  logic        sts_vld;
  logic [15:0] sts_len;
  logic        sts_too_long;

  always #10 clk = ~clk;

  hdlc_rx_len_limiter u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .max_len(max_len),
    .out_vld(out_vld), .out_data(out_data), .sts_vld(sts_vld),
    .sts_len(sts_len), .sts_too_long(sts_too_long)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // frame-level model state
  bit    m_open = 1'b0;
  int    m_cnt  = 0;
  int    m_lim  = 0;
  bit    e_vld  = 1'b0;
  logic [7:0] e_data = '0;
  bit    e_sts  = 1'b0;
  int    e_len  = 0;
  bit    e_tl   = 1'b0;
  string cur_tag = "R10";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(cur_tag, "out_vld", int'(out_vld), int'(e_vld));
    if (e_vld) chk(cur_tag, "out_data", int'(out_data), int'(e_data));
    chk(cur_tag, "sts_vld", int'(sts_vld), int'(e_sts));
    if (e_sts) begin
      chk(cur_tag, "sts_len", int'(sts_len), e_len);
      chk(cur_tag, "sts_too_long", int'(sts_too_long), int'(e_tl));
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // one input cycle: check previous results, drive new inputs, predict their results
  task automatic cyc(input bit v, input logic [7:0] d, input bit s, input bit e,
                     input logic [15:0] ml, input string tag);
    @(negedge clk);
    check_outputs();
    in_vld = v; in_data = d; in_sof = s; in_eof = e; max_len = ml;
    e_vld = 1'b0;
    e_sts = 1'b0;
    if (s) begin
      m_open = 1'b1;
      m_cnt  = 0;
      m_lim  = int'(ml);
    end
    if (m_open && v) begin
      m_cnt++;
      if (m_cnt <= m_lim) begin
        e_vld  = 1'b1;
        e_data = d;
      end
    end
    if (m_open && e) begin
      e_sts  = 1'b1;
      e_len  = imin(m_cnt, m_lim);
      e_tl   = (m_cnt > m_lim);
      m_open = 1'b0;
    end
    cur_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 16'd0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24681357));
    rst_n = 1'b0; in_vld = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0; max_len = '0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet during reset
    chk("R10", "out_vld in reset", int'(out_vld), 0);
    chk("R10", "sts_vld in reset", int'(sts_vld), 0);
    rst_n = 1'b1;

    // R1 / R3: exact-limit frame, with a gap inside
    cyc(1'b1, 8'hA0, 1'b1, 1'b0, 16'd4, "R10");
    cyc(1'b1, 8'hA1, 1'b0, 1'b0, 16'd4, "R1");
    cyc(1'b0, 8'hFF, 1'b0, 1'b0, 16'd4, "R1");
    cyc(1'b1, 8'hA2, 1'b0, 1'b0, 16'd4, "R1");
    cyc(1'b1, 8'hA3, 1'b0, 1'b1, 16'd4, "R1");
    idle(1, "R3");

    // R4 / R6: six bytes against a limit of three
    cyc(1'b1, 8'hB0, 1'b1, 1'b0, 16'd3, "R4");
    for (int i = 1; i < 5; i++) cyc(1'b1, 8'hB0 + 8'(i), 1'b0, 1'b0, 16'd3, "R4");
    cyc(1'b1, 8'hB5, 1'b0, 1'b1, 16'd3, "R4");
    idle(1, "R6");

    // R2: stray bytes and an end strobe outside any frame
    cyc(1'b1, 8'hC0, 1'b0, 1'b0, 16'd5, "R2");
    cyc(1'b1, 8'hC1, 1'b0, 1'b1, 16'd5, "R2");
    idle(1, "R2");

    // R7: restart while in discard phase, and restart mid-frame
    cyc(1'b1, 8'hD0, 1'b1, 1'b0, 16'd1, "R7");
    cyc(1'b1, 8'hD1, 1'b0, 1'b0, 16'd1, "R7");
    cyc(1'b1, 8'hD2, 1'b1, 1'b0, 16'd5, "R7");
    cyc(1'b1, 8'hD3, 1'b0, 1'b0, 16'd5, "R7");
    cyc(1'b1, 8'hD4, 1'b1, 1'b0, 16'd2, "R7");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 16'd2, "R7");
    idle(1, "R7");

    // R8: single-cycle frames with and without a byte
    cyc(1'b1, 8'hE0, 1'b1, 1'b1, 16'd3, "R8");
    cyc(1'b0, 8'h00, 1'b1, 1'b1, 16'd3, "R8");
    idle(1, "R8");

    // R9: limit changes mid-frame
    cyc(1'b1, 8'hF0, 1'b1, 1'b0, 16'd2, "R9");
    cyc(1'b1, 8'hF1, 1'b0, 1'b0, 16'd9, "R9");
    cyc(1'b1, 8'hF2, 1'b0, 1'b0, 16'd9, "R9");
    cyc(1'b1, 8'hF3, 1'b0, 1'b1, 16'd9, "R9");
    idle(1, "R9");

    // R11: zero limit, with bytes and empty
    cyc(1'b1, 8'h11, 1'b1, 1'b0, 16'd0, "R11");
    cyc(1'b1, 8'h12, 1'b0, 1'b1, 16'd0, "R11");
    cyc(1'b0, 8'h00, 1'b1, 1'b1, 16'd0, "R11");
    idle(1, "R11");

    // R5: random streams
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) != 0, 8'($urandom), ($urandom % 12) == 0,
          ($urandom % 8) == 0, 16'($urandom % 10), "R5");
    end
    idle(2, "R5");
    finish_run();
  end

endmodule